// File: doc/BRIEF.md
# Selectable-Order Burst Address Generator

This block produces the address sequence of a four-beat burst for a synchronous burst memory. When a burst opens, it captures a starting address from the external bus. Each later cycle with the advance strobe asserted moves it to the next beat, and the low-order address bits follow either an interleaved (XOR) order or a linear wrap-around order. The address bits above the beat field pass through from the captured start unchanged.

The ordering input is static in normal use and is sampled continuously. When advance is deasserted, the current address is held and the cycle becomes a wait state. The burst position is kept, so the sequence resumes from where it stopped. Both strobes are active low, and a load always wins over an advance in the same cycle. Memory storage, chip-select decoding and the data path belong to the surrounding design.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rstN` is low, and after it is released, `beatIdx` is 0 and `addrOut` is 0 until the first load.
- R2: A rising clock edge with `loadN` low captures `extAddr`. From the next cycle `addrOut` equals `extAddr` and `beatIdx` is 0, whatever the value of `advN` in that cycle.
- R3: A rising edge with `loadN` high and `advN` low increases `beatIdx` by one, modulo 4.
- R4: A rising edge with both `loadN` and `advN` high leaves `beatIdx` and `addrOut` unchanged (wait cycle).
- R5: With `modeIlv` = 1, the two low bits of `addrOut` equal the captured start low bits XOR `beatIdx`. For example, a start of 01 gives 01,00,11,10.
- R6: With `modeIlv` = 0, the two low bits of `addrOut` equal (start low bits + `beatIdx`) mod 4. For example, a start of 01 gives 01,10,11,00.
- R7: Bits `addrOut[ADDR_W-1:2]` always equal the same bits of the last captured address.
- R8: An advance on the fourth beat wraps `beatIdx` to 0, and `addrOut` returns to the first address of the same burst.
- R9: `modeIlv` acts combinationally. A change in mode alters the low address bits in the same cycle, without a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadN | input | 1 | Active-low burst start; captures extAddr |
| advN | input | 1 | Active-low advance to the next beat |
| modeIlv | input | 1 | 1 = interleaved order, 0 = linear order |
| extAddr | input | ADDR_W | External starting address |
| addrOut | output | ADDR_W | Current burst address |
| beatIdx | output | 2 | Beat index within the burst (0..3) |

## Verification
A corrupted beat counter shows at once as a wrong `beatIdx`. In the cycle after the faulty edge it also shows as a wrong low address pair, so every check after an advance or a wait reveals it. A bad captured start shows in the upper address bits from the cycle after the load. A mixed-up order mux shows only on beats 1 to 3, because beat 0 is the same in both orders. For that reason the stimulus visits every start value and every beat in both modes, and it toggles the mode in the middle of bursts.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;

  typedef struct packed {
    logic loadEn;
    logic stepEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadN,
  input  logic              advN,
  output ctrlStrobes_t      strobes,
  output logic [BEAT_W-1:0] beatCnt
);
  always_comb begin
    strobes.loadEn = !loadN;
    strobes.stepEn = loadN && !advN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                beatCnt <= '0;
    else if (strobes.loadEn) beatCnt <= '0;
    else if (strobes.stepEn) beatCnt <= beatCnt + 1'b1;
  end

  // R2: a load restarts the beat count
  p_load_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !loadN |=> (beatCnt == '0));
  // R3: an advance steps the count by one (wraps, R8)
  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && !advN) |=> (beatCnt == BEAT_W'($past(beatCnt) + 1)));
  // R4: a wait cycle holds the count
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (loadN && advN) |=> $stable(beatCnt));
endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [BEAT_W-1:0] beatCnt,
  input  logic              modeIlv,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] addrOut
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] startReg;
  logic [BEAT_W-1:0] lowIlv;
  logic [BEAT_W-1:0] lowLin;
  logic [BEAT_W-1:0] lowSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               startReg <= '0;
    else if (strobes.loadEn) startReg <= extAddr;
  end

  always_comb begin
    lowIlv  = startReg[BEAT_W-1:0] ^ beatCnt;
    lowLin  = startReg[BEAT_W-1:0] + beatCnt;
    lowSel  = modeIlv ? lowIlv : lowLin;
    addrOut = {startReg[ADDR_W-1:BEAT_W], lowSel};
  end

  // R7: upper bits change only through a load
  p_upper_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadEn |=> $stable(addrOut[ADDR_W-1:BEAT_W]));
  // R2: beat zero presents the captured start itself in either order
  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rstN)
    (beatCnt == '0) |-> (addrOut == startReg));
  // R6: linear order, second beat is start plus one
  p_lin_second_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!modeIlv && beatCnt == BEAT_W'(1)) |->
      (addrOut[BEAT_W-1:0] == BEAT_W'(startReg[BEAT_W-1:0] + 1)));
  // R5: interleaved order, second beat flips bit zero
  p_ilv_second_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeIlv && beatCnt == BEAT_W'(1)) |->
      (addrOut[0] != startReg[0] && addrOut[1] == startReg[1]));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadN,
  input  logic              advN,
  input  logic              modeIlv,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] addrOut,
  output logic [1:0]        beatIdx
);
  ctrlStrobes_t      strobes;
  logic [BEAT_W-1:0] beatCnt;

  burst_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .loadN(loadN), .advN(advN),
    .strobes(strobes), .beatCnt(beatCnt)
  );

  burst_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .beatCnt(beatCnt),
    .modeIlv(modeIlv), .extAddr(extAddr), .addrOut(addrOut)
  );

  assign beatIdx = beatCnt;
endmodule

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadN = 1'b1;
  logic          advN = 1'b1;
  logic          modeIlv = 1'b1;
  logic [AW-1:0] extAddr = '0;
  logic [AW-1:0] addrOut;
  logic [1:0]    beatIdx;

  int vectors = 0;
  int miscompares = 0;
  logic [AW-1:0] mStart = '0;
  logic [1:0]    mBeat = '0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .loadN(loadN), .advN(advN),
    .modeIlv(modeIlv), .extAddr(extAddr), .addrOut(addrOut), .beatIdx(beatIdx)
  );

  function automatic logic [AW-1:0] expAddr(logic [AW-1:0] st, logic [1:0] b, logic ilv);
    logic [1:0] lo;
    lo = ilv ? (st[1:0] ^ b) : 2'(st[1:0] + b);
    return {st[AW-1:2], lo};
  endfunction

  task automatic check(string req);
    logic [AW-1:0] ea;
    ea = expAddr(mStart, mBeat, modeIlv);
    vectors++;
    if (addrOut !== ea || beatIdx !== mBeat) begin
      miscompares++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               req, addrOut, beatIdx, ea, mBeat);
    end
  endtask

  // drive at negedge, clock once, update model, check at next negedge
  task automatic cyc(logic ld, logic ad, logic md, logic [AW-1:0] ea, string req);
    loadN = ld; advN = ad; modeIlv = md; extAddr = ea;
    @(posedge clk);
    if (!ld) begin mStart = ea; mBeat = '0; end
    else if (!ad) mBeat = mBeat + 2'd1;
    @(negedge clk);
    check(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release");

    // every start, both modes, full burst plus wrap (R5, R6, R8)
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        cyc(1'b0, 1'b1, m[0], AW'(32'h5A3C0) | AW'(s), "R2 load");
        for (int b = 0; b < 3; b++) cyc(1'b1, 1'b0, m[0], '0, m[0] ? "R5 interleave" : "R6 linear");
        cyc(1'b1, 1'b0, m[0], '0, "R8 wrap");
      end
    end

    // load overrides advance (R2)
    cyc(1'b0, 1'b1, 1'b0, AW'(32'hABCD2), "R2 load");
    cyc(1'b1, 1'b0, 1'b0, '0, "R3 step");
    cyc(1'b0, 1'b0, 1'b0, AW'(32'h12341), "R2 load beats advance");
    // wait cycles hold (R4)
    cyc(1'b1, 1'b0, 1'b0, AW'(32'hFFFFF), "R3 step");
    cyc(1'b1, 1'b1, 1'b0, AW'(32'hFFFFF), "R4 wait");
    cyc(1'b1, 1'b1, 1'b0, '0, "R4 wait");
    cyc(1'b1, 1'b0, 1'b0, '0, "R3 resume");
    // mode flips mid-burst (R9) and upper bits stay (R7)
    cyc(1'b1, 1'b1, 1'b1, AW'(32'h00003), "R9 mode flip");
    cyc(1'b1, 1'b1, 1'b0, AW'(32'h00003), "R9 mode flip back");
    cyc(1'b1, 1'b0, 1'b1, AW'(32'hFFFFC), "R7 upper hold");

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic ld;
      ld = ($urandom % 5) == 0;
      cyc(!ld, ($urandom % 3) == 0, 1'($urandom), AW'($urandom), "R3 R4 R5 R6 R7 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule